// File: doc/BRIEF.md
# Dual-Target Parallel Bus Interface Controller

This controller sits between a 16-bit host I/O port and two target buses. One is a graphics memory bus with a 16-bit halfword address space. The other is a peripheral bus whose devices have 6-bit addresses. The host sends 8-bit command bytes to choose what happens next. It can load or read either address register, stream halfwords to or from graphics memory, move single halfwords over the peripheral bus, acknowledge peripheral interrupts, and change the interrupt gating. All data on the host side is 16 bits wide. Both target buses are modelled as request/acknowledge ports. A request is held until the target acknowledges it or until a timeout counter expires.

The host side has three channels. Commands use `cmd_valid`/`cmd_ready`. Write data uses `wr_valid`/`wr_ready`. Read data uses `rd_valid`/`rd_ready`. A beat moves only on a cycle where valid and ready are both high. While a target-bus cycle is in flight, `cmd_ready` and `wr_ready` stay low, which applies back-pressure to the host. A read halfword is held on `rd_data` until the host accepts it. A status byte reports the busy state, data available, the pending peripheral request, the two bus-timeout flags, and a secondary input.

Top module: `gpi_ctrl`

## Requirements
- R1: After reset the status byte reads 0x00 when `aux_in` is low, `irq` is low, `rd_valid` is low, and both address registers read back as zero.
- R2: Command 0x24 makes the next host halfword the graphics address. Command 0x20 returns that address on the read channel.
- R3: Command 0x25 starts a write stream. Each later host halfword is written to graphics memory at the current address, and the address then increases by one, wrapping at 16 bits. While the bus cycle is outstanding, status bit 3 (busy) is high and `wr_ready` is low.
- R4: Command 0x21 starts a read stream. Each returned halfword sets status bit 7 and increments the address. Once the host accepts a halfword, the next read is issued. Command 0x29 clears bit 7 and returns to idle. The address then points one past the last accepted halfword, because one read was fetched ahead.
- R5: Command 0x26 makes the low byte of the next host halfword the peripheral address byte. Bits 7:6 of that byte are a condition code and bits 5:0 are the device address. Command 0x22 returns the byte, zero-extended. Code 00 only loads the byte and starts no bus cycle.
- R6: Command 0x27 writes the next host halfword to the peripheral at the device address (`p_we`=1, `p_op`=00). Command 0x23 reads from that device (`p_op`=10). Status bit 7 is set only if the peripheral flags returned data with `p_rdv`.
- R7: Condition code 10 runs a peripheral read, with bit 7 set only when `p_rdv` is high. Condition code 11 runs one pulse cycle (`p_op`=11).
- R8: A `p_srq` pulse sets status bit 4. Condition code 01 with bit 4 set runs an acknowledge cycle (`p_op`=01), presents `p_rdata[5:0]` as the readable requester address, sets bit 7 and clears bit 4. With bit 4 clear, code 01 runs no bus cycle.
- R9: If a graphics cycle gets no acknowledge within TMO cycles, status bit 2 is set, the request drops and the block goes idle. A peripheral cycle that times out sets bit 6 instead. The next accepted command clears both flags.
- R10: Byte 0x40 enables and arms the interrupt, 0x80 disables it, and 0xC0 disarms it. `irq` is high only when the interrupt is enabled, armed, and status bit 4 or bit 2 is set.
- R11: Command 0x28 restores the full reset state, including disabling the interrupt. Command 0x2A clears the peripheral address byte, bit 4 and bit 6, and leaves the graphics address unchanged.
- R12: Status bit 5 follows `aux_in`. `rd_valid` equals status bit 7, and `rd_data` holds until `rd_ready` accepts it, which clears bit 7.
- R13: A command byte with no defined meaning changes no state except clearing the timeout flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command byte offered |
| cmd_ready | output | 1 | Command can be taken (no bus cycle in flight) |
| cmd_byte | input | 8 | Command code |
| wr_valid | input | 1 | Host halfword offered |
| wr_ready | output | 1 | A halfword is expected |
| wr_data | input | DW | Host write halfword |
| rd_valid | output | 1 | Read halfword available |
| rd_ready | input | 1 | Host accepts read halfword |
| rd_data | output | DW | Read halfword |
| aux_in | input | 1 | Secondary input, mirrored in status bit 5 |
| status | output | 8 | Status byte |
| irq | output | 1 | Interrupt request |
| g_req | output | 1 | Graphics bus request |
| g_we | output | 1 | Graphics write (1) or read (0) |
| g_addr | output | GAW | Graphics address |
| g_wdata | output | DW | Graphics write data |
| g_ack | input | 1 | Graphics acknowledge |
| g_rdata | input | DW | Graphics read data |
| p_req | output | 1 | Peripheral bus request |
| p_we | output | 1 | Peripheral data write |
| p_op | output | 2 | Peripheral operation code |
| p_addr | output | PAW | Peripheral device address |
| p_wdata | output | DW | Peripheral write data |
| p_ack | input | 1 | Peripheral acknowledge |
| p_rdv | input | 1 | Peripheral returned data |
| p_rdata | input | DW | Peripheral read data |
| p_srq | input | 1 | Peripheral service request pulse |

## Verification
The graphics write stream starts just below the top of the address space. A design that does not wrap the address register, or that advances it twice per beat, leaves the data at the wrong locations and reads back the wrong final address. The read stream is stopped after the host has accepted several halfwords. A design that does not fetch ahead, or that leaves data-ready set after the stop, then shows a wrong final address or a stale read beat. All 64 device addresses are swept for write and read, and the upper quarter of them returns no data. This catches a design that sets data-ready without `p_rdv`. The bench also acknowledges with no request pending, toggles the interrupt gating, and forces timeouts on both buses. These tests expose a bus cycle that should not run, a request flag that is not cleared, an interrupt that ignores the disarm, and a timeout flag that survives the next command.

// File: rtl/gpi_pkg.sv
package gpi_pkg;
  typedef enum logic [3:0] {
    OP_NONE, OP_RD_GADDR, OP_RD_GDATA, OP_RD_PADDR, OP_RD_PDATA,
    OP_WR_GADDR, OP_WR_GDATA, OP_WR_PADDR, OP_WR_PDATA,
    OP_RESET, OP_STOP, OP_RESET_P, OP_IRQ_EN, OP_IRQ_DIS, OP_IRQ_DISARM
  } op_e;

  typedef enum logic [1:0] {
    CC_LOAD = 2'b00, CC_ACK = 2'b01, CC_READ = 2'b10, CC_PULSE = 2'b11
  } cc_e;

  typedef enum logic [2:0] {
    S_IDLE, S_GADDR, S_PADDR, S_GWR, S_PWR, S_GRD, S_GBUS, S_PBUS
  } st_e;

  localparam int ST_GBTO = 2;
  localparam int ST_BUSY = 3;
  localparam int ST_PREQ = 4;
  localparam int ST_AUX  = 5;
  localparam int ST_PBTO = 6;
  localparam int ST_IDR  = 7;
endpackage

// File: rtl/gpi_cmd_dec.sv
module gpi_cmd_dec
  import gpi_pkg::*;
(
  input  logic [7:0] code,
  output op_e        op
);
  always_comb begin
    unique case (code)
      8'h20:   op = OP_RD_GADDR;
      8'h21:   op = OP_RD_GDATA;
      8'h22:   op = OP_RD_PADDR;
      8'h23:   op = OP_RD_PDATA;
      8'h24:   op = OP_WR_GADDR;
      8'h25:   op = OP_WR_GDATA;
      8'h26:   op = OP_WR_PADDR;
      8'h27:   op = OP_WR_PDATA;
      8'h28:   op = OP_RESET;
      8'h29:   op = OP_STOP;
      8'h2A:   op = OP_RESET_P;
      8'h40:   op = OP_IRQ_EN;
      8'h80:   op = OP_IRQ_DIS;
      8'hC0:   op = OP_IRQ_DISARM;
      default: op = OP_NONE;
    endcase
  end
endmodule

// File: rtl/gpi_bus_port.sv
module gpi_bus_port #(
  parameter int TMO = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic ack,
  output logic req,
  output logic done,
  output logic tmo
);
  localparam int CW = $clog2(TMO + 1);
  logic [CW-1:0] cnt;

  assign done = req && ack;
  assign tmo  = req && !ack && (cnt == CW'(TMO - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req <= 1'b0;
      cnt <= '0;
    end else if (start) begin
      req <= 1'b1;
      cnt <= '0;
    end else if (req) begin
      if (ack || tmo) req <= 1'b0;
      else            cnt <= cnt + 1'b1;
    end
  end

  // R3: a request is held until the target answers or the window closes
  p_req_held_r3: assert property (@(posedge clk) disable iff (!rst_n)
    req && !ack && !tmo |=> req);
  // R3: an acknowledged request is withdrawn on the next cycle
  p_drop_after_ack_r3: assert property (@(posedge clk) disable iff (!rst_n)
    done && !start |=> !req);
endmodule

// File: rtl/gpi_irq.sv
module gpi_irq (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic en_c,
  input  logic dis_c,
  input  logic disarm_c,
  input  logic src,
  output logic irq
);
  logic en, armed;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en    <= 1'b0;
      armed <= 1'b0;
    end else if (clr) begin
      en    <= 1'b0;
      armed <= 1'b0;
    end else begin
      if (en_c)     begin en <= 1'b1; armed <= 1'b1; end
      if (dis_c)    en    <= 1'b0;
      if (disarm_c) armed <= 1'b0;
    end
  end

  assign irq = en && armed && src;

  p_irq_off_dis_r10: assert property (@(posedge clk) disable iff (!rst_n)
    dis_c && !en_c |=> !irq);
  p_irq_off_disarm_r10: assert property (@(posedge clk) disable iff (!rst_n)
    disarm_c && !en_c |=> !irq);
  p_irq_off_clr_r11: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> !irq);
endmodule

// File: rtl/gpi_ctrl.sv
module gpi_ctrl
  import gpi_pkg::*;
#(
  parameter int DW  = 16,
  parameter int GAW = 16,
  parameter int PAW = 6,
  parameter int TMO = 16
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cmd_valid,
  output logic           cmd_ready,
  input  logic [7:0]     cmd_byte,
  input  logic           wr_valid,
  output logic           wr_ready,
  input  logic [DW-1:0]  wr_data,
  output logic           rd_valid,
  input  logic           rd_ready,
  output logic [DW-1:0]  rd_data,
  input  logic           aux_in,
  output logic [7:0]     status,
  output logic           irq,
  output logic           g_req,
  output logic           g_we,
  output logic [GAW-1:0] g_addr,
  output logic [DW-1:0]  g_wdata,
  input  logic           g_ack,
  input  logic [DW-1:0]  g_rdata,
  output logic           p_req,
  output logic           p_we,
  output logic [1:0]     p_op,
  output logic [PAW-1:0] p_addr,
  output logic [DW-1:0]  p_wdata,
  input  logic           p_ack,
  input  logic           p_rdv,
  input  logic [DW-1:0]  p_rdata,
  input  logic           p_srq
);
  localparam int PBW = PAW + 2;

  st_e            st, st_n;
  logic [GAW-1:0] gaddr, gaddr_n;
  logic [PBW-1:0] pab, pab_n;
  logic [DW-1:0]  wbuf, wbuf_n, rbuf, rbuf_n;
  logic           idr, idr_n, gbto, gbto_n, pbto, pbto_n, preq, preq_n;
  logic           gwe, gwe_n, pwe, pwe_n;
  cc_e            pop, pop_n;
  logic           g_start, p_start, g_done, p_done, g_tmo, p_tmo;
  logic           soft_rst, en_c, dis_c, disarm_c;
  logic           busy, cmd_fire, wr_fire, rd_fire;
  op_e            op;

  gpi_cmd_dec u_dec (.code(cmd_byte), .op(op));

  gpi_bus_port #(.TMO(TMO)) u_gport (
    .clk(clk), .rst_n(rst_n), .start(g_start), .ack(g_ack),
    .req(g_req), .done(g_done), .tmo(g_tmo));

  gpi_bus_port #(.TMO(TMO)) u_pport (
    .clk(clk), .rst_n(rst_n), .start(p_start), .ack(p_ack),
    .req(p_req), .done(p_done), .tmo(p_tmo));

  gpi_irq u_irq (
    .clk(clk), .rst_n(rst_n), .clr(soft_rst), .en_c(en_c), .dis_c(dis_c),
    .disarm_c(disarm_c), .src(preq || gbto), .irq(irq));

  assign busy      = (st == S_GBUS) || (st == S_PBUS);
  assign cmd_ready = !busy;
  assign cmd_fire  = cmd_valid && cmd_ready;
  assign wr_ready  = (st == S_GADDR || st == S_PADDR || st == S_GWR || st == S_PWR)
                     && !cmd_valid;
  assign wr_fire   = wr_valid && wr_ready;
  assign rd_valid  = idr;
  assign rd_data   = rbuf;
  assign rd_fire   = idr && rd_ready;
  assign status    = {idr, pbto, aux_in, preq, busy, gbto, 2'b00};

  assign g_we    = gwe;
  assign g_addr  = gaddr;
  assign g_wdata = wbuf;
  assign p_we    = pwe;
  assign p_op    = pop;
  assign p_addr  = pab[PAW-1:0];
  assign p_wdata = wbuf;

  always_comb begin
    st_n = st;  gaddr_n = gaddr;  pab_n = pab;  wbuf_n = wbuf;  rbuf_n = rbuf;
    idr_n = idr && !rd_fire;  gbto_n = gbto;  pbto_n = pbto;  preq_n = preq;
    gwe_n = gwe;  pwe_n = pwe;  pop_n = pop;
    g_start = 1'b0;  p_start = 1'b0;
    soft_rst = 1'b0;  en_c = 1'b0;  dis_c = 1'b0;  disarm_c = 1'b0;

    if (g_tmo) begin gbto_n = 1'b1; st_n = S_IDLE; end
    if (g_done) begin
      gaddr_n = gaddr + 1'b1;
      if (gwe) st_n = S_GWR;
      else begin rbuf_n = g_rdata; idr_n = 1'b1; st_n = S_GRD; end
    end
    if (p_tmo) begin pbto_n = 1'b1; st_n = S_IDLE; end
    if (p_done) begin
      st_n = S_IDLE;
      if (pop == CC_ACK) begin
        rbuf_n = DW'(p_rdata[PAW-1:0]); idr_n = 1'b1; preq_n = 1'b0;
      end else if (pop == CC_READ && p_rdv) begin
        rbuf_n = p_rdata; idr_n = 1'b1;
      end
    end

    if (cmd_fire) begin
      gbto_n = 1'b0;
      pbto_n = 1'b0;
      unique case (op)
        OP_RD_GADDR:   begin rbuf_n = DW'(gaddr); idr_n = 1'b1; st_n = S_IDLE; end
        OP_RD_PADDR:   begin rbuf_n = DW'(pab);   idr_n = 1'b1; st_n = S_IDLE; end
        OP_RD_GDATA:   begin g_start = 1'b1; gwe_n = 1'b0; st_n = S_GBUS; end
        OP_RD_PDATA:   begin p_start = 1'b1; pwe_n = 1'b0; pop_n = CC_READ; st_n = S_PBUS; end
        OP_WR_GADDR:   st_n = S_GADDR;
        OP_WR_GDATA:   st_n = S_GWR;
        OP_WR_PADDR:   st_n = S_PADDR;
        OP_WR_PDATA:   st_n = S_PWR;
        OP_RESET:      soft_rst = 1'b1;
        OP_STOP:       begin idr_n = 1'b0; st_n = S_IDLE; end
        OP_RESET_P:    begin pab_n = '0; preq_n = 1'b0; st_n = S_IDLE; end
        OP_IRQ_EN:     en_c = 1'b1;
        OP_IRQ_DIS:    dis_c = 1'b1;
        OP_IRQ_DISARM: disarm_c = 1'b1;
        default:       ;
      endcase
    end else if (wr_fire) begin
      unique case (st)
        S_GADDR: begin gaddr_n = wr_data[GAW-1:0]; st_n = S_IDLE; end
        S_PADDR: begin
          pab_n = wr_data[PBW-1:0];
          pwe_n = 1'b0;
          pop_n = cc_e'(wr_data[PBW-1:PBW-2]);
          st_n  = S_IDLE;
          if (pop_n == CC_READ || pop_n == CC_PULSE || (pop_n == CC_ACK && preq)) begin
            p_start = 1'b1;
            st_n    = S_PBUS;
          end
        end
        S_GWR: begin wbuf_n = wr_data; gwe_n = 1'b1; g_start = 1'b1; st_n = S_GBUS; end
        S_PWR: begin
          wbuf_n = wr_data; pwe_n = 1'b1; pop_n = CC_LOAD; p_start = 1'b1; st_n = S_PBUS;
        end
        default: ;
      endcase
    end else if (st == S_GRD && rd_fire) begin
      g_start = 1'b1; gwe_n = 1'b0; st_n = S_GBUS;
    end

    if (p_srq) preq_n = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; gaddr <= '0; pab <= '0; wbuf <= '0; rbuf <= '0;
      idr <= 1'b0; gbto <= 1'b0; pbto <= 1'b0; preq <= 1'b0;
      gwe <= 1'b0; pwe <= 1'b0; pop <= CC_LOAD;
    end else if (soft_rst) begin
      st <= S_IDLE; gaddr <= '0; pab <= '0; wbuf <= '0; rbuf <= '0;
      idr <= 1'b0; gbto <= 1'b0; pbto <= 1'b0; preq <= 1'b0;
      gwe <= 1'b0; pwe <= 1'b0; pop <= CC_LOAD;
    end else begin
      st <= st_n; gaddr <= gaddr_n; pab <= pab_n; wbuf <= wbuf_n; rbuf <= rbuf_n;
      idr <= idr_n; gbto <= gbto_n; pbto <= pbto_n; preq <= preq_n;
      gwe <= gwe_n; pwe <= pwe_n; pop <= pop_n;
    end
  end

  // R3: a bus request in flight is always reported as busy
  p_busy_with_req_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (g_req || p_req) |-> status[ST_BUSY]);
  // R3: the graphics address does not move under an open request
  p_gaddr_stable_r3: assert property (@(posedge clk) disable iff (!rst_n)
    g_req && !g_ack |=> !g_req || $stable(g_addr));
  // R4: stop-read leaves nothing on the read channel
  p_stop_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_fire && cmd_byte == 8'h29 |=> !rd_valid);
  // R8: an acknowledge cycle retires the request flag
  p_ack_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
    p_done && p_op == 2'b01 && !p_srq |=> !status[ST_PREQ]);
  // R9: any accepted command wipes both timeout flags
  p_tmo_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_fire |=> !status[ST_GBTO] && !status[ST_PBTO]);
  // R12: unaccepted read data is held
  p_rd_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid && !rd_ready && !cmd_fire && !status[ST_BUSY] |=> rd_valid && $stable(rd_data));
endmodule

// File: tb/sim_gpi_ctrl.sv
`timescale 1ns/1ps
module sim_gpi_ctrl;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic cmd_valid = 1'b0, cmd_ready;
  logic [7:0] cmd_byte = 8'h00;
  logic wr_valid = 1'b0, wr_ready;
  logic [15:0] wr_data = 16'h0;
  logic rd_valid, rd_ready = 1'b0;
  logic [15:0] rd_data;
  logic aux_in = 1'b0;
  logic [7:0] status;
  logic irq;
  logic g_req, g_we, g_ack = 1'b0;
  logic [15:0] g_addr, g_wdata, g_rdata = 16'h0;
  logic p_req, p_we, p_ack = 1'b0, p_rdv = 1'b0, p_srq = 1'b0;
  logic [1:0] p_op;
  logic [5:0] p_addr;
  logic [15:0] p_wdata, p_rdata = 16'h0;

  gpi_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_byte(cmd_byte), .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_data(wr_data),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_data(rd_data), .aux_in(aux_in),
    .status(status), .irq(irq), .g_req(g_req), .g_we(g_we), .g_addr(g_addr),
    .g_wdata(g_wdata), .g_ack(g_ack), .g_rdata(g_rdata), .p_req(p_req), .p_we(p_we),
    .p_op(p_op), .p_addr(p_addr), .p_wdata(p_wdata), .p_ack(p_ack), .p_rdv(p_rdv),
    .p_rdata(p_rdata), .p_srq(p_srq));

  // target models
  logic [15:0] gmem [256];
  logic [15:0] pmem [64];
  logic g_hang = 1'b0, p_hang = 1'b0;
  logic [5:0] src_addr = 6'd0;
  int p_cyc = 0, pulses = 0;

  always @(posedge clk) begin
    g_ack <= 1'b0;
    if (g_req && !g_ack && !g_hang) begin
      g_ack <= 1'b1;
      if (g_we) gmem[g_addr[7:0]] <= g_wdata;
      g_rdata <= gmem[g_addr[7:0]];
    end
  end

  always @(posedge clk) begin
    p_ack <= 1'b0;
    if (p_req && !p_ack && !p_hang) begin
      p_ack <= 1'b1;
      p_cyc <= p_cyc + 1;
      if (p_we) pmem[p_addr] <= p_wdata;
      if (p_op == 2'b01) p_rdata <= {10'd0, src_addr};
      else               p_rdata <= pmem[p_addr];
      p_rdv <= (p_op == 2'b10) && (p_addr < 6'd48);
      if (p_op == 2'b11 && !p_we) pulses <= pulses + 1;
    end
  end

  int n_run = 0, n_fail = 0;
  bit finished = 1'b0;

  task automatic chk(input string r, input logic [31:0] got, input logic [31:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", r, got, exp);
    end
  endtask

  task automatic cmd(input logic [7:0] b);
    @(negedge clk);
    while (!cmd_ready) @(negedge clk);
    cmd_valid = 1'b1; cmd_byte = b;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic wr(input logic [15:0] d);
    @(negedge clk);
    while (!wr_ready) @(negedge clk);
    wr_valid = 1'b1; wr_data = d;
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  task automatic idle_wait;
    @(negedge clk);
    while (status[3]) @(negedge clk);
  endtask

  task automatic rd(output logic [15:0] d);
    int n = 0;
    @(negedge clk);
    while (!rd_valid && n < 60) begin @(negedge clk); n++; end
    if (!rd_valid) d = 16'hDEAD;
    else begin
      d = rd_data;
      rd_ready = 1'b1;
      @(negedge clk);
      rd_ready = 1'b0;
    end
  endtask

  task automatic pulse_srq(input logic [5:0] a);
    @(negedge clk);
    src_addr = a; p_srq = 1'b1;
    @(negedge clk);
    p_srq = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL R1 watchdog: got no completion expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [15:0] d;
    logic [15:0] base;
    int cyc0, pul0;
    for (int k = 0; k < 256; k++) gmem[k] = 16'(k * 7 + 16'h100);
    for (int k = 0; k < 64; k++) pmem[k] = 16'h0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    @(negedge clk);
    chk("R1 status", status, 8'h00);
    chk("R1 irq", irq, 0);
    chk("R1 rd_valid", rd_valid, 0);
    cmd(8'h20); rd(d); chk("R1 gaddr", d, 16'h0000);
    cmd(8'h22); rd(d); chk("R1 paddr", d, 16'h0000);

    // R12 secondary input
    aux_in = 1'b1; @(negedge clk); chk("R12 aux bit", status[5], 1);
    aux_in = 1'b0; @(negedge clk); chk("R12 aux clear", status[5], 0);

    // R2 address write/read-back, R12 handshake
    foreach (base[i]) ;
    for (int i = 0; i < 4; i++) begin
      logic [15:0] a;
      a = (i == 0) ? 16'h0000 : (i == 1) ? 16'hFFFF : (i == 2) ? 16'hA5C3 : 16'h1234;
      cmd(8'h24); wr(a); cmd(8'h20);
      @(negedge clk);
      chk("R12 idr before pop", status[7], 1);
      chk("R12 rd_valid mirrors idr", rd_valid, status[7]);
      rd(d); chk("R2 gaddr readback", d, a);
      chk("R12 idr after pop", status[7], 0);
    end

    // R13 undefined commands
    cmd(8'h33); cmd(8'h00); cmd(8'hFF);
    cmd(8'h20); rd(d); chk("R13 gaddr kept", d, 16'h1234);

    // R3 write stream across the wrap point
    base = 16'hFFFA;
    cmd(8'h24); wr(base); cmd(8'h25);
    for (int i = 0; i < 12; i++) begin
      wr(16'(i * 16'h0911 + 16'h3C00));
      if (i == 0) begin
        chk("R3 busy during cycle", status[3], 1);
        chk("R3 wr_ready low while busy", wr_ready, 0);
      end
    end
    idle_wait();
    for (int i = 0; i < 12; i++)
      chk("R3 stream data", gmem[8'(base + 16'(i))], 16'(i * 16'h0911 + 16'h3C00));
    cmd(8'h20); rd(d); chk("R3 final address wraps", d, 16'h0006);

    // R4 read stream with one fetched ahead
    cmd(8'h24); wr(16'h0040); cmd(8'h21);
    for (int i = 0; i < 10; i++) begin
      rd(d); chk("R4 stream data", d, 16'((16'h40 + i) * 7 + 16'h100));
    end
    cmd(8'h29);
    @(negedge clk);
    chk("R4 stop clears rd_valid", rd_valid, 0);
    chk("R4 stop clears idr", status[7], 0);
    cmd(8'h20); rd(d); chk("R4 address after stop", d, 16'h004B);

    // R5 load-only peripheral address sweep
    cyc0 = p_cyc;
    for (int p = 0; p < 64; p++) begin
      cmd(8'h26); wr(16'(p));
      cmd(8'h22); rd(d); chk("R5 paddr readback", d, 16'(p));
    end
    chk("R5 no bus cycles for code 00", p_cyc, cyc0);

    // R6 peripheral data write/read sweep
    for (int p = 0; p < 64; p++) begin
      logic [15:0] v;
      v = 16'(p * 16'h0101) ^ 16'h5A3C;
      cmd(8'h26); wr(16'(p)); cmd(8'h27); wr(v); idle_wait();
      chk("R6 peripheral write", pmem[p], v);
      cmd(8'h23); idle_wait();
      if (p < 48) begin rd(d); chk("R6 peripheral read", d, v); end
      else chk("R6 no data no idr", rd_valid, 0);
    end

    // R7 code 10 read and code 11 pulse
    cmd(8'h26); wr({8'h00, 2'b10, 6'd5}); idle_wait();
    rd(d); chk("R7 code read data", d, 16'(5 * 16'h0101) ^ 16'h5A3C);
    cmd(8'h26); wr({8'h00, 2'b10, 6'd50}); idle_wait();
    chk("R7 code read no data", rd_valid, 0);
    pul0 = pulses;
    cmd(8'h26); wr({8'h00, 2'b11, 6'd9}); idle_wait();
    chk("R7 one pulse", pulses, pul0 + 1);

    // R8 / R10 request, acknowledge and gating
    cmd(8'h40);
    @(negedge clk); chk("R10 no source no irq", irq, 0);
    cyc0 = p_cyc;
    cmd(8'h26); wr({8'h00, 2'b01, 6'd0}); idle_wait();
    chk("R8 ack without request no cycle", p_cyc, cyc0);
    chk("R8 ack without request no data", rd_valid, 0);
    pulse_srq(6'd37);
    chk("R8 request flag", status[4], 1);
    chk("R10 irq on request", irq, 1);
    cmd(8'hC0); @(negedge clk); chk("R10 disarm", irq, 0);
    cmd(8'h40); @(negedge clk); chk("R10 re-enable", irq, 1);
    cmd(8'h80); @(negedge clk); chk("R10 disable", irq, 0);
    cmd(8'h40); @(negedge clk); chk("R10 enable again", irq, 1);
    cmd(8'h26); wr({8'h00, 2'b01, 6'd0}); idle_wait();
    rd(d); chk("R8 requester address", d, 16'd37);
    chk("R8 request cleared", status[4], 0);
    chk("R10 irq drops", irq, 0);

    // R9 timeouts
    g_hang = 1'b1;
    cmd(8'h24); wr(16'h0100); cmd(8'h25); wr(16'hBEEF); idle_wait();
    chk("R9 graphics timeout flag", status[2], 1);
    chk("R9 graphics req dropped", g_req, 0);
    chk("R10 irq on timeout", irq, 1);
    g_hang = 1'b0;
    cmd(8'h33); @(negedge clk);
    chk("R9 timeout cleared by command", status[2], 0);
    chk("R9 irq gone", irq, 0);
    p_hang = 1'b1;
    cmd(8'h26); wr(16'h0003); cmd(8'h27); wr(16'h0001); idle_wait();
    chk("R9 peripheral timeout flag", status[6], 1);
    chk("R9 peripheral req dropped", p_req, 0);
    p_hang = 1'b0;
    cmd(8'h20); @(negedge clk);
    chk("R9 peripheral flag cleared", status[6], 0);
    rd(d);

    // R11 peripheral-side reset and full reset
    cmd(8'h24); wr(16'h7777); cmd(8'h26); wr(16'h0015);
    pulse_srq(6'd2);
    chk("R11 irq before", irq, 1);
    cmd(8'h2A); @(negedge clk);
    chk("R11 request cleared", status[4], 0);
    cmd(8'h22); rd(d); chk("R11 paddr cleared", d, 16'h0000);
    cmd(8'h20); rd(d); chk("R11 gaddr kept", d, 16'h7777);
    pulse_srq(6'd2);
    chk("R11 still enabled", irq, 1);
    cmd(8'h28); @(negedge clk);
    chk("R11 full reset status", status, 8'h00);
    chk("R11 full reset irq", irq, 0);
    pulse_srq(6'd2);
    chk("R11 enable cleared", irq, 0);
    cmd(8'h20); rd(d); chk("R11 gaddr zero", d, 16'h0000);

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule